// File: doc/BRIEF.md
# Four-Channel Colour Acquisition Sequencer

This block is the digital core of a four-channel light sensor: red, green, blue and an unfiltered clear channel. Each channel has a digital pulse input that stands in for its analog front end. A host writes a small byte-wide register bank to program the block and to trigger work. The block then runs the work on its own.

A sensor-reading request measures the channels one after another. For each channel it counts the core clocks in which that channel's pulse input is high, over that channel's programmed number of time slots. The count goes into a 10-bit result register. An offset request takes one slot per channel and compares the count with a dark reference. It stores the signed difference in sign-magnitude form. With trim enabled, each new reading is corrected by its channel's stored offset.

A sleep bit freezes the whole sequencer. The sleep bit is accepted only together with external-clock mode. Each channel also has a 4-bit gain code, which the block only holds and presents on an output bus.

Top module: `color_acq_seq`

Register map (byte-wide; channel index c is 0 = red, 1 = green, 2 = blue, 3 = clear):

| Address | Content |
|---|---|
| 0x00 | request: bit0 = reading, bit1 = offset capture |
| 0x01 | mode: bit0 = trim, bit1 = sleep, bit2 = external clock |
| 0x04+c | gain code, bits 3:0 |
| 0x08+2c / 0x09+2c | slot count bits 7:0 / bits 11:8 |
| 0x10+2c / 0x11+2c | result bits 7:0 / bits 9:8 |
| 0x18+c | offset, bit7 = sign (1 = negative), bits 6:0 = magnitude |

## Requirements
- R1: After reset:
  - request and mode registers read 0x00;
  - every gain code reads 0x0F;
  - every slot count, result and offset reads 0x00;
  - unmapped addresses always read 0x00.
- R2: Writing 1 to request bit0 starts a reading. The bit reads 1 from the next cycle until all four results are stored, and then reads 0 by itself. Writing 0 to a request bit has no effect.
- R3: A channel's result equals the number of core clocks in which its pulse input was high, over a window of slots x 16 clocks, saturated at 1023. A slot count of 0 gives a result of 0.
- R4: Channels are measured in the order red, green, blue, clear. Results are stored at 0x10+2c (bits 7:0) and 0x11+2c (bits 9:8), and the upper six bits of the high byte read 0.
- R5: The slot count is 12 bits wide: the low byte at 0x08+2c and bits 11:8 from bits 3:0 of the byte at 0x09+2c. The upper nibble of that high byte reads 0.
- R6: Writing 1 to request bit1 captures offsets. Each channel is counted for one slot, and the offset is count minus 8, saturated to +/-127. It is stored at 0x18+c as bit7 = sign (1 = negative) and bits 6:0 = magnitude. Bit1 clears after the fourth offset is written.
- R7: With mode bit0 set, each stored reading equals the raw count minus its channel's signed offset, clamped to 0..1023. With the bit clear, the raw count is stored.
- R8: The sleep bit is accepted only when the same write to the mode register also sets bit2. Otherwise it reads 0. Clearing bit2 also clears sleep.
- R9: While sleep is set, the sequencer makes no progress, pulse inputs are ignored and requests stay pending. Once sleep is cleared, the work completes.
- R10: A request written while a measurement runs is held and executed afterwards. When both requests are pending, the reading runs first, and the request register reads both bits set.
- R11: Result and offset registers ignore host writes.
- R12: Gain code c is presented on gain_cap[4c+3:4c]. Writes store bits 3:0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_waddr | input | 5 | register write address |
| reg_wdata | input | 8 | register write data |
| reg_raddr | input | 5 | register read address |
| reg_rdata | output | 8 | register read data (combinational from reg_raddr) |
| pulse_in | input | 4 | per-channel light pulses, bit c = channel c |
| gain_cap | output | 16 | per-channel gain codes, 4 bits each |

## Verification
Most faults in this block show up in the host-visible registers within one measurement.
- A wrong slot counter, channel index or saturation point shows up as a result off by a whole multiple of 4, 8 or 16, or as the wrong channel's value.
- A broken self-clear or request hold shows up as a request bit that never drops and a poll that never finishes.
- A bad sign or clamp in the offset path shows up in the offset bytes as soon as a capture completes, and in the trimmed results on the next reading.
- A sleep gate that leaks lets the request bit fall and the results change while the block should be frozen. This is visible within a few hundred cycles.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_REQ  = 5'h00;
  localparam logic [ADDR_W-1:0] A_MODE = 5'h01;
  localparam int A_GAIN = 'h04;
  localparam int A_SLOT = 'h08;
  localparam int A_RES  = 'h10;
  localparam int A_OFS  = 'h18;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_INTEG, S_STORE, S_FINISH
  } seq_state_t;

  typedef enum logic {M_READ, M_OFS} meas_mode_t;
endpackage

// File: rtl/acq_offset_math.sv
`timescale 1ns/1ps
module acq_offset_math #(
  parameter int RES_W     = 10,
  parameter int OFS_MAG_W = 7,
  parameter int DARK_REF  = 8
) (
  input  logic [RES_W-1:0]     count,
  input  logic [OFS_MAG_W:0]   ofs_code,
  input  logic                 trim_en,
  output logic [RES_W-1:0]     data_val,
  output logic [OFS_MAG_W:0]   ofs_val
);
  localparam int WIDE = ((RES_W > OFS_MAG_W) ? RES_W : OFS_MAG_W) + 2;
  localparam int MAG_MAX = (1 << OFS_MAG_W) - 1;
  localparam int RES_MAX = (1 << RES_W) - 1;

  logic signed [WIDE-1:0] cnt_s, diff, absd, offs, corr;

  always_comb begin
    cnt_s = $signed({{(WIDE-RES_W){1'b0}}, count});
    diff  = cnt_s - $signed(WIDE'(DARK_REF));
    absd  = (diff < 0) ? -diff : diff;
    ofs_val[OFS_MAG_W] = (diff < 0);
    if (absd > $signed(WIDE'(MAG_MAX)))
      ofs_val[OFS_MAG_W-1:0] = OFS_MAG_W'(MAG_MAX);
    else
      ofs_val[OFS_MAG_W-1:0] = absd[OFS_MAG_W-1:0];

    offs = $signed({{(WIDE-OFS_MAG_W){1'b0}}, ofs_code[OFS_MAG_W-1:0]});
    if (ofs_code[OFS_MAG_W]) offs = -offs;
    corr = trim_en ? (cnt_s - offs) : cnt_s;
    if (corr < 0)
      data_val = '0;
    else if (corr > $signed(WIDE'(RES_MAX)))
      data_val = '1;
    else
      data_val = corr[RES_W-1:0];
  end
endmodule

// File: rtl/acq_seq.sv
`timescale 1ns/1ps
module acq_seq import acq_pkg::*; #(
  parameter int RES_W     = 10,
  parameter int INT_W     = 12,
  parameter int SLOT_CLKS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_en,
  input  logic                 set_rd,
  input  logic                 set_ofs,
  input  logic [NCH*INT_W-1:0] slot_len,
  input  logic [NCH-1:0]       pulse_in,
  output logic                 busy_rd,
  output logic                 busy_ofs,
  output logic                 st_data,
  output logic                 st_ofs,
  output logic [CH_W-1:0]      cur_ch,
  output logic [RES_W-1:0]     cur_acc,
  output seq_state_t           cur_state
);
  localparam int SC_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SLOT_CLKS - 1);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

  seq_state_t          st;
  meas_mode_t          mode;
  logic [CH_W-1:0]     ch;
  logic [INT_W-1:0]    slots_left;
  logic [SC_W-1:0]     clk_cnt;
  logic [RES_W-1:0]    acc;
  logic                rd_pend, rd_act, of_pend, of_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode <= M_READ; ch <= '0;
      slots_left <= '0; clk_cnt <= '0; acc <= '0;
      rd_pend <= 1'b0; rd_act <= 1'b0; of_pend <= 1'b0; of_act <= 1'b0;
    end else begin
      if (set_rd)  rd_pend <= 1'b1;
      if (set_ofs) of_pend <= 1'b1;
      if (core_en) begin
        case (st)
          S_IDLE: begin
            if (rd_pend) begin
              rd_pend <= set_rd;
              rd_act  <= 1'b1;
              mode    <= M_READ;
              ch      <= '0;
              st      <= S_SETUP;
            end else if (of_pend) begin
              of_pend <= set_ofs;
              of_act  <= 1'b1;
              mode    <= M_OFS;
              ch      <= '0;
              st      <= S_SETUP;
            end
          end
          S_SETUP: begin
            slots_left <= (mode == M_READ) ? slot_len[ch*INT_W +: INT_W] : INT_W'(1);
            clk_cnt    <= '0;
            acc        <= '0;
            st         <= S_INTEG;
          end
          S_INTEG: begin
            if (slots_left == '0) begin
              st <= S_STORE;
            end else begin
              if (pulse_in[ch] && (acc != '1)) acc <= acc + 1'b1;
              if (clk_cnt == SC_LAST) begin
                clk_cnt    <= '0;
                slots_left <= slots_left - 1'b1;
              end else begin
                clk_cnt <= clk_cnt + 1'b1;
              end
            end
          end
          S_STORE: begin
            if (ch == CH_LAST) st <= S_FINISH;
            else begin
              ch <= ch + 1'b1;
              st <= S_SETUP;
            end
          end
          S_FINISH: begin
            if (mode == M_READ) rd_act <= 1'b0;
            else                of_act <= 1'b0;
            st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy_rd   = rd_pend | rd_act;
  assign busy_ofs  = of_pend | of_act;
  assign st_data   = core_en && (st == S_STORE) && (mode == M_READ);
  assign st_ofs    = core_en && (st == S_STORE) && (mode == M_OFS);
  assign cur_ch    = ch;
  assign cur_acc   = acc;
  assign cur_state = st;
endmodule

// File: rtl/acq_regfile.sv
`timescale 1ns/1ps
module acq_regfile import acq_pkg::*; #(
  parameter int RES_W  = 10,
  parameter int INT_W  = 12,
  parameter int OFS_CW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [7:0]            wdata,
  input  logic [ADDR_W-1:0]     raddr,
  output logic [7:0]            rdata,
  input  logic                  busy_rd,
  input  logic                  busy_ofs,
  input  logic                  st_data,
  input  logic                  st_ofs,
  input  logic [CH_W-1:0]       st_ch,
  input  logic [RES_W-1:0]      data_val,
  input  logic [OFS_CW-1:0]     ofs_val,
  output logic                  set_rd,
  output logic                  set_ofs,
  output logic                  trim_en,
  output logic                  sleep,
  output logic                  ext_clk,
  output logic [NCH*4-1:0]      gain_flat,
  output logic [NCH*INT_W-1:0]  slot_flat,
  output logic [NCH*RES_W-1:0]  data_flat,
  output logic [NCH*OFS_CW-1:0] ofs_flat
);
  assign set_rd  = we && (waddr == A_REQ) && wdata[0];
  assign set_ofs = we && (waddr == A_REQ) && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_en <= 1'b0; sleep <= 1'b0; ext_clk <= 1'b0;
    end else if (we && waddr == A_MODE) begin
      trim_en <= wdata[0];
      ext_clk <= wdata[2];
      sleep   <= wdata[1] & wdata[2];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] AG  = ADDR_W'(A_GAIN + c);
    localparam logic [ADDR_W-1:0] ASL = ADDR_W'(A_SLOT + 2*c);
    localparam logic [ADDR_W-1:0] ASH = ADDR_W'(A_SLOT + 2*c + 1);
    logic [3:0]        gain_q;
    logic [INT_W-1:0]  slot_q;
    logic [RES_W-1:0]  data_q;
    logic [OFS_CW-1:0] ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q <= 4'hF; slot_q <= '0; data_q <= '0; ofs_q <= '0;
      end else begin
        if (we && waddr == AG)  gain_q <= wdata[3:0];
        if (we && waddr == ASL) slot_q[7:0] <= wdata;
        if (we && waddr == ASH) slot_q[INT_W-1:8] <= wdata[INT_W-9:0];
        if (st_data && st_ch == CH_W'(c)) data_q <= data_val;
        if (st_ofs  && st_ch == CH_W'(c)) ofs_q  <= ofs_val;
      end
    end

    assign gain_flat[4*c +: 4]          = gain_q;
    assign slot_flat[INT_W*c +: INT_W]  = slot_q;
    assign data_flat[RES_W*c +: RES_W]  = data_q;
    assign ofs_flat[OFS_CW*c +: OFS_CW] = ofs_q;
  end

  always_comb begin
    rdata = '0;
    if (raddr == A_REQ)  rdata = {6'b0, busy_ofs, busy_rd};
    if (raddr == A_MODE) rdata = {5'b0, ext_clk, sleep, trim_en};
    for (int c = 0; c < NCH; c++) begin
      if (raddr == ADDR_W'(A_GAIN + c))      rdata = {4'b0, gain_flat[4*c +: 4]};
      if (raddr == ADDR_W'(A_SLOT + 2*c))    rdata = slot_flat[INT_W*c +: 8];
      if (raddr == ADDR_W'(A_SLOT + 2*c + 1)) rdata = 8'(slot_flat[INT_W*c + 8 +: INT_W-8]);
      if (raddr == ADDR_W'(A_RES + 2*c))     rdata = data_flat[RES_W*c +: 8];
      if (raddr == ADDR_W'(A_RES + 2*c + 1)) rdata = 8'(data_flat[RES_W*c + 8 +: RES_W-8]);
      if (raddr == ADDR_W'(A_OFS + c))       rdata = 8'(ofs_flat[OFS_CW*c +: OFS_CW]);
    end
  end
endmodule

// File: rtl/color_acq_seq.sv
`timescale 1ns/1ps
module color_acq_seq import acq_pkg::*; #(
  parameter int RES_W     = 10,
  parameter int INT_W     = 12,
  parameter int SLOT_CLKS = 16,
  parameter int DARK_REF  = 8,
  parameter int OFS_MAG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [7:0]        reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [7:0]        reg_rdata,
  input  logic [NCH-1:0]    pulse_in,
  output logic [NCH*4-1:0]  gain_cap
);
  localparam int OFS_CW = OFS_MAG_W + 1;

  logic                  set_rd, set_ofs, trim_en, cfg_sleep, cfg_ext;
  logic                  busy_rd, busy_ofs, st_data, st_ofs;
  logic [CH_W-1:0]       seq_ch;
  logic [RES_W-1:0]      seq_acc, data_val;
  logic [OFS_CW-1:0]     ofs_val, ofs_sel;
  seq_state_t            seq_st;
  logic [NCH*INT_W-1:0]  slot_flat;
  logic [NCH*RES_W-1:0]  data_flat;
  logic [NCH*OFS_CW-1:0] ofs_flat;

  assign ofs_sel = ofs_flat[seq_ch*OFS_CW +: OFS_CW];

  acq_regfile #(.RES_W(RES_W), .INT_W(INT_W), .OFS_CW(OFS_CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .busy_rd(busy_rd), .busy_ofs(busy_ofs),
    .st_data(st_data), .st_ofs(st_ofs), .st_ch(seq_ch), .data_val(data_val),
    .ofs_val(ofs_val), .set_rd(set_rd), .set_ofs(set_ofs), .trim_en(trim_en),
    .sleep(cfg_sleep), .ext_clk(cfg_ext), .gain_flat(gain_cap),
    .slot_flat(slot_flat), .data_flat(data_flat), .ofs_flat(ofs_flat)
  );

  acq_seq #(.RES_W(RES_W), .INT_W(INT_W), .SLOT_CLKS(SLOT_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .core_en(!cfg_sleep), .set_rd(set_rd),
    .set_ofs(set_ofs), .slot_len(slot_flat), .pulse_in(pulse_in),
    .busy_rd(busy_rd), .busy_ofs(busy_ofs), .st_data(st_data), .st_ofs(st_ofs),
    .cur_ch(seq_ch), .cur_acc(seq_acc), .cur_state(seq_st)
  );

  acq_offset_math #(.RES_W(RES_W), .OFS_MAG_W(OFS_MAG_W), .DARK_REF(DARK_REF)) u_math (
    .count(seq_acc), .ofs_code(ofs_sel), .trim_en(trim_en),
    .data_val(data_val), .ofs_val(ofs_val)
  );
endmodule

// File: rtl/acq_checker.sv
`timescale 1ns/1ps
module acq_checker import acq_pkg::*; #(
  parameter int RES_W = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sleep,
  input logic                 ext_clk,
  input seq_state_t           st,
  input logic [CH_W-1:0]      ch,
  input logic [RES_W-1:0]     acc,
  input logic                 busy_rd,
  input logic                 st_data,
  input logic                 st_ofs,
  input logic [NCH*RES_W-1:0] data_flat
);
  p_sleep_needs_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> ext_clk);

  p_frozen_in_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(st) && $stable(ch) && $stable(acc)));

  p_store_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_data |-> busy_rd);

  p_self_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_rd) |-> ($past(st) == S_FINISH));

  p_channel_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_data || st_ofs) && ch != CH_W'(NCH-1)) |=> (ch == CH_W'($past(ch) + 1'b1)));

  p_results_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !st_data |=> $stable(data_flat));
endmodule

bind color_acq_seq acq_checker #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep(cfg_sleep), .ext_clk(cfg_ext), .st(seq_st),
  .ch(seq_ch), .acc(seq_acc), .busy_rd(busy_rd), .st_data(st_data),
  .st_ofs(st_ofs), .data_flat(data_flat)
);

// File: tb/color_acq_seq_bench.sv
`timescale 1ns/1ps
module color_acq_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_waddr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [4:0]  reg_raddr = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  pulse_in = '0;
  logic [15:0] gain_cap;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int pmode [4];
  int cyc = 0;

  always #2 clk = ~clk;

  color_acq_seq u_color_acq_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pulse_in(pulse_in), .gain_cap(gain_cap)
  );

  // pulse patterns: 0 off, 1 always, 2 every other clock, 3 one clock in four
  initial begin
    for (int c = 0; c < 4; c++) pmode[c] = 0;
    forever begin
      @(negedge clk);
      cyc++;
      for (int c = 0; c < 4; c++)
        case (pmode[c])
          1: pulse_in[c] = 1'b1;
          2: pulse_in[c] = cyc[0];
          3: pulse_in[c] = (cyc[1:0] == 2'b00);
          default: pulse_in[c] = 1'b0;
        endcase
    end
  end

  function automatic int exp_cnt(int m, int n);
    int v;
    case (m)
      1: v = 16*n;
      2: v = 8*n;
      3: v = 4*n;
      default: v = 0;
    endcase
    return (v > 1023) ? 1023 : v;
  endfunction

  function automatic int exp_ofs(int m);
    int d = exp_cnt(m, 1) - 8;
    return (d < 0) ? (8'h80 | (-d)) : d;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 5'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    reg_raddr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic set_slots(int c, int v);
    wr(8 + 2*c, v & 8'hFF);
    wr(9 + 2*c, (v >> 8) & 8'h0F);
  endtask

  task automatic wait_idle(string tag);
    int v;
    for (int i = 0; i < 90000; i++) begin
      rd(0, v);
      if (v == 0) return;
    end
    chk(tag, v, 0);
  endtask

  task automatic chk_res(string tag, int c, int exp);
    int lo, hi;
    rd(16 + 2*c, lo);
    rd(17 + 2*c, hi);
    chk(tag, (hi << 8) | lo, exp);
    chk(tag, hi & 8'hFC, 0);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    int sl [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, v); chk("R1 req", v, 0);
    rd(1, v); chk("R1 mode", v, 0);
    for (int c = 0; c < 4; c++) begin
      rd(4 + c, v);      chk("R1 gain", v, 8'h0F);
      rd(8 + 2*c, v);    chk("R1 slot", v, 0);
      rd(16 + 2*c, v);   chk("R1 res", v, 0);
      rd(24 + c, v);     chk("R1 ofs", v, 0);
    end
    rd(5'h1F, v); chk("R1 unmapped", v, 0);
    chk("R12 gain reset port", gain_cap, 16'hFFFF);

    // R12 gain pass-through
    wr(6, 8'hA5);
    rd(6, v); chk("R12 gain rd", v, 8'h05);
    chk("R12 gain port", gain_cap, 16'hF5FF);

    // R5 slot count width
    set_slots(1, 12'hABC);
    rd(8 + 2, v); chk("R5 slot lo", v, 8'hBC);
    wr(9 + 2, 8'hFA);
    rd(9 + 2, v); chk("R5 slot hi", v, 8'h0A);

    // R3 R4 R2 sweep of patterns and slot counts
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        pmode[c] = (m + c) % 4;
        sl[c] = c + m + 1;
        set_slots(c, sl[c]);
      end
      wr(0, 8'h01);
      rd(0, v); chk("R2 busy", v, 1);
      wait_idle("R2 self clear");
      for (int c = 0; c < 4; c++) chk_res("R3 R4 sweep", c, exp_cnt(pmode[c], sl[c]));
    end

    // R3 saturation and zero slots
    pmode[0] = 1; pmode[1] = 1; pmode[2] = 1; pmode[3] = 3;
    set_slots(0, 64); set_slots(1, 0); set_slots(2, 12'hFFF); set_slots(3, 3);
    wr(0, 8'h01);
    wait_idle("R2 sat clear");
    chk_res("R3 sat", 0, 1023);
    chk_res("R3 zero", 1, 0);
    chk_res("R3 max slots", 2, 1023);
    chk_res("R3 quarter", 3, 12);

    // R6 offset capture
    pmode[0] = 1; pmode[1] = 0; pmode[2] = 2; pmode[3] = 3;
    wr(0, 8'h02);
    rd(0, v); chk("R6 busy", v, 2);
    wait_idle("R6 self clear");
    for (int c = 0; c < 4; c++) begin
      rd(24 + c, v); chk("R6 offset", v, exp_ofs(pmode[c]));
    end

    // R7 trim with clamps: offsets +8, -8, 0, -4
    wr(1, 8'h01);
    pmode[0] = 0; pmode[1] = 0; pmode[2] = 2; pmode[3] = 1;
    set_slots(0, 1); set_slots(1, 1); set_slots(2, 4); set_slots(3, 64);
    wr(0, 8'h01);
    wait_idle("R7 clear");
    chk_res("R7 clamp low", 0, 0);
    chk_res("R7 neg offset", 1, 8);
    chk_res("R7 zero offset", 2, 32);
    chk_res("R7 clamp high", 3, 1023);
    wr(1, 8'h00);
    wr(0, 8'h01);
    wait_idle("R7 off clear");
    chk_res("R7 raw", 1, 0);
    chk_res("R7 raw", 2, 32);

    // R10 held request
    for (int c = 0; c < 4; c++) begin pmode[c] = 1; set_slots(c, 2); end
    wr(0, 8'h01);
    wr(0, 8'h02);
    rd(0, v); chk("R10 both pending", v, 3);
    wait_idle("R10 clear");
    for (int c = 0; c < 4; c++) begin
      chk_res("R10 reading", c, 32);
      rd(24 + c, v); chk("R10 offset", v, 8'h08);
    end

    // R8 sleep acceptance
    wr(1, 8'h02);
    rd(1, v); chk("R8 sleep rejected", v, 0);
    wr(1, 8'h06);
    rd(1, v); chk("R8 sleep accepted", v, 6);

    // R9 frozen while asleep
    for (int c = 0; c < 4; c++) set_slots(c, 1);
    wr(0, 8'h01);
    repeat (200) @(negedge clk);
    rd(0, v); chk("R9 pending in sleep", v, 1);
    chk_res("R9 results held", 0, 32);
    for (int c = 0; c < 4; c++) pmode[c] = 0;
    wr(1, 8'h04);
    rd(1, v); chk("R8 ext drop", v, 4);
    wait_idle("R9 wake clear");
    for (int c = 0; c < 4; c++) chk_res("R9 pulses ignored asleep", c, 0);

    // R11 read-only registers and unmapped writes
    wr(16, 8'hFF);
    rd(16, v); chk("R11 result write", v, 0);
    wr(25, 8'h33);
    rd(25, v); chk("R11 offset write", v, 8'h08);
    wr(2, 8'h77);
    rd(2, v); chk("R1 unmapped write", v, 0);
    wr(0, 8'h00);
    rd(0, v); chk("R2 zero write", v, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule